// File: doc/BRIEF.md
# Pulse-distance IR frame decoder

This block turns one packet of run-length samples from an infrared receiver front end into a 32-bit remote-control scan code. Each input byte describes one run of constant line level: bit 7 gives the level (1 = mark, 0 = space) and bits 6:0 give the run length minus one, in sample periods. The decoder first looks for a long leader mark followed by a long leader space. It then reads data bits as mark/space pairs, where a long space means 1 and a short space means 0.

When the byte flagged as last in the packet is accepted, the block reports one result on the next cycle. It pulses a valid strobe with the decoded code if all 32 bits arrived and the command byte matches its inverse. In every other case it pulses an error strobe and presents the all-ones code. The decoder accepts one byte per clock cycle and never stalls. It returns to leader search after every packet.

Top module: `ir_pd_decoder`

## Requirements
- R1: Out of reset `in_ready` is 1, `out_valid` and `out_err` are 0 and `out_code` is 0; a byte is taken on every clock edge where `in_valid` and `in_ready` are both 1, with bit 7 the level (1 = mark) and bits 6:0 the run length minus one.
- R2: At the start of each packet the run accumulator is preset to 80. Mark bytes add their length. A space byte moves to the leader-space phase, loading its own length, only when the accumulated mark exceeds 80; otherwise it clears the accumulator to 0.
- R3: In the leader-space phase, space bytes add their length. A mark byte starts bit decoding, with that mark counted as the first data mark, only when the accumulated space exceeds 40; otherwise it clears the accumulator and the decoder stays in the leader-space phase.
- R4: During bit decoding, a data mark whose total length exceeds 26 aborts the frame with an error.
- R5: A data space whose total exceeds 53 aborts the frame. Otherwise the space is ended by the next mark byte, which yields bit 1 if the space exceeds 26 and bit 0 if not. Bits fill the code from bit 0 upward.
- R6: Once 32 bits are decoded, further bytes of the packet are ignored until its last byte.
- R7: The cycle after the last byte is taken, exactly one of `out_valid` and `out_err` is 1 for one cycle. After an error `out_code` is 32'hFFFFFFFF, and `out_code` holds its value between results.
- R8: `out_valid` is raised only when 32 bits were decoded and code bits 23:16 XOR bits 31:24 equal 8'hFF. A packet that ends before that point, including one that ends before the leader completes, and a frame that fails the check both give an error.
- R9: Run accumulators are 12 bits wide and saturate at 4095 instead of wrapping.
- R10: After every packet, valid or not, the decoder restarts leader search with the preset accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Run-length byte present |
| in_data | input | 8 | Level in bit 7, length minus one in bits 6:0 |
| in_last | input | 1 | Byte is the last of its packet |
| in_ready | output | 1 | Decoder can take a byte (always 1 after reset) |
| out_code | output | 32 | Decoded scan code, or all ones after an error |
| out_valid | output | 1 | One-cycle strobe: valid frame decoded |
| out_err | output | 1 | One-cycle strobe: packet failed to decode |

## Verification
The bound checker tests the result protocol on every cycle. It checks that a strobe follows a last byte and never appears otherwise, that the two strobes never coincide, that an error carries the all-ones code and a valid result passes the inverse check, and that the code holds between results. It also checks that a leader-search accumulator never drops while marks are added, and that a completed frame stays completed until packet end. Only the bench's scenarios can show the thresholds themselves. These include the exact 80, 40, 26 and 53 sample boundaries, bit order, the leader-space retry, truncated packets, and overlong runs that would wrap a non-saturating counter.

// File: rtl/ir_pd_pkg.sv
package ir_pd_pkg;
    localparam int CODE_W = 32;

    typedef enum logic [2:0] {
        PH_LEAD_MARK,
        PH_LEAD_SPACE,
        PH_BIT_MARK,
        PH_BIT_SPACE,
        PH_DONE,
        PH_FAIL
    } ir_phase_e;
endpackage

// File: rtl/ir_sat_add.sv
module ir_sat_add #(
    parameter int W = 12
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    logic [W:0] full;

    always_comb begin
        full = {1'b0, a} + {1'b0, b};
        y    = full[W] ? {W{1'b1}} : full[W-1:0];
    end
endmodule

// File: rtl/ir_code_check.sv
module ir_code_check #(
    parameter int CODE_W = 32
) (
    input  logic [CODE_W-1:0] code,
    output logic              ok
);
    localparam int BYTE_W = 8;
    localparam int CMD_LO = CODE_W - 2 * BYTE_W;
    localparam int INV_LO = CODE_W - BYTE_W;

    logic [BYTE_W-1:0] cmd_byte;
    logic [BYTE_W-1:0] inv_byte;

    always_comb begin
        cmd_byte = code[CMD_LO +: BYTE_W];
        inv_byte = code[INV_LO +: BYTE_W];
        ok       = ((cmd_byte ^ inv_byte) == {BYTE_W{1'b1}});
    end
endmodule

// File: rtl/ir_pd_decoder.sv
module ir_pd_decoder #(
    parameter int ACC_W          = 12,
    parameter int LEAD_MARK_MIN  = 80,
    parameter int LEAD_SPACE_MIN = 40,
    parameter int DATA_MARK_MAX  = 26,
    parameter int SPACE_ONE_MIN  = 26,
    parameter int DATA_SPACE_MAX = 53
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [7:0]  in_data,
    input  logic        in_last,
    output logic        in_ready,
    output logic [31:0] out_code,
    output logic        out_valid,
    output logic        out_err
);
    import ir_pd_pkg::*;

    localparam int                 BIT_W     = $clog2(CODE_W);
    localparam logic [ACC_W-1:0]   PRESET    = ACC_W'(LEAD_MARK_MIN);
    localparam logic [ACC_W-1:0]   TH_LMARK  = ACC_W'(LEAD_MARK_MIN);
    localparam logic [ACC_W-1:0]   TH_LSPACE = ACC_W'(LEAD_SPACE_MIN);
    localparam logic [ACC_W-1:0]   TH_DMARK  = ACC_W'(DATA_MARK_MAX);
    localparam logic [ACC_W-1:0]   TH_ONE    = ACC_W'(SPACE_ONE_MIN);
    localparam logic [ACC_W-1:0]   TH_DSPACE = ACC_W'(DATA_SPACE_MAX);
    localparam logic [BIT_W-1:0]   LAST_BIT  = BIT_W'(CODE_W - 1);

    typedef struct packed {
        ir_phase_e          ph;
        logic [ACC_W-1:0]   acc;
        logic [BIT_W-1:0]   nbit;
        logic [CODE_W-1:0]  code;
        logic [CODE_W-1:0]  out_code;
        logic               out_valid;
        logic               out_err;
    } dec_state_t;

    dec_state_t q, step, d;

    ir_phase_e          ph_q;
    logic [ACC_W-1:0]   acc_q;
    logic               is_mark;
    logic               take;
    logic [ACC_W-1:0]   run_len;
    logic [ACC_W-1:0]   acc_sum;
    logic               code_ok;

    assign ph_q     = q.ph;
    assign acc_q    = q.acc;
    assign in_ready = 1'b1;
    assign take     = in_valid && in_ready;
    assign is_mark  = in_data[7];
    assign run_len  = ACC_W'(in_data[6:0]) + ACC_W'(1);

    ir_sat_add #(.W(ACC_W)) u_sum (
        .a (q.acc),
        .b (run_len),
        .y (acc_sum)
    );

    ir_code_check #(.CODE_W(CODE_W)) u_chk (
        .code (step.code),
        .ok   (code_ok)
    );

    // Advance the frame parser by one run-length byte.
    always_comb begin
        step = q;
        step.out_valid = 1'b0;
        step.out_err   = 1'b0;
        if (take) begin
            unique case (q.ph)
                PH_LEAD_MARK: begin
                    if (is_mark) begin
                        step.acc = acc_sum;
                    end else if (q.acc > TH_LMARK) begin
                        step.ph  = PH_LEAD_SPACE;
                        step.acc = run_len;
                    end else begin
                        step.acc = '0;
                    end
                end
                PH_LEAD_SPACE: begin
                    if (!is_mark) begin
                        step.acc = acc_sum;
                    end else if (q.acc > TH_LSPACE) begin
                        step.ph   = PH_BIT_MARK;
                        step.acc  = run_len;
                        step.nbit = '0;
                        step.code = '0;
                    end else begin
                        step.acc = '0;
                    end
                end
                PH_BIT_MARK: begin
                    if (is_mark) begin
                        step.acc = acc_sum;
                    end else if (q.acc > TH_DMARK) begin
                        step.ph = PH_FAIL;
                    end else begin
                        step.ph  = PH_BIT_SPACE;
                        step.acc = run_len;
                    end
                end
                PH_BIT_SPACE: begin
                    if (!is_mark) begin
                        step.acc = acc_sum;
                    end else if (q.acc > TH_DSPACE) begin
                        step.ph = PH_FAIL;
                    end else begin
                        step.code[q.nbit] = (q.acc > TH_ONE);
                        step.nbit         = q.nbit + BIT_W'(1);
                        step.acc          = run_len;
                        step.ph           = (q.nbit == LAST_BIT) ? PH_DONE : PH_BIT_MARK;
                    end
                end
                default: begin
                end
            endcase
        end
    end

    // Packet end: publish the result and rearm leader search.
    always_comb begin
        d = step;
        if (take && in_last) begin
            if (step.ph == PH_DONE && code_ok) begin
                d.out_valid = 1'b1;
                d.out_code  = step.code;
            end else begin
                d.out_err  = 1'b1;
                d.out_code = '1;
            end
            d.ph   = PH_LEAD_MARK;
            d.acc  = PRESET;
            d.nbit = '0;
            d.code = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.ph        <= PH_LEAD_MARK;
            q.acc       <= PRESET;
            q.nbit      <= '0;
            q.code      <= '0;
            q.out_code  <= '0;
            q.out_valid <= 1'b0;
            q.out_err   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign out_code  = q.out_code;
    assign out_valid = q.out_valid;
    assign out_err   = q.out_err;
endmodule

// File: rtl/ir_pd_checker.sv
module ir_pd_checker #(
    parameter int ACC_W = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic                 in_ready,
    input  logic [7:0]           in_data,
    input  logic                 in_last,
    input  logic [31:0]          out_code,
    input  logic                 out_valid,
    input  logic                 out_err,
    input  ir_pd_pkg::ir_phase_e ph_q,
    input  logic [ACC_W-1:0]     acc_q
);
    import ir_pd_pkg::*;

    // R7: the two result strobes never coincide
    a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && out_err));

    // R7: an error result carries the all-ones code
    a_r7_err_code: assert property (@(posedge clk) disable iff (!rst_n)
        out_err |-> (out_code == 32'hFFFF_FFFF));

    // R7: a result follows every accepted last byte
    a_r7_result_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_last) |=> (out_valid || out_err));

    // R7: no result without a last byte
    a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_ready && in_last) |=> !(out_valid || out_err));

    // R7: the code holds between results
    a_r7_code_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_ready && in_last) |=> $stable(out_code));

    // R8: a valid result passes the inverse-command check
    a_r8_valid_check: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_code[23:16] ^ out_code[31:24]) == 8'hFF));

    // R9: adding a mark during leader search never lowers the accumulator
    a_r9_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_data[7] && !in_last && ph_q == PH_LEAD_MARK)
        |=> (acc_q >= $past(acc_q)));

    // R6: a completed frame stays completed until its packet ends
    a_r6_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_DONE && !(in_valid && in_ready && in_last)) |=> (ph_q == PH_DONE));

    // R10: after a packet end the decoder is back in leader search
    a_r10_rearm: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_last) |=> (ph_q == PH_LEAD_MARK));
endmodule

bind ir_pd_decoder ir_pd_checker #(.ACC_W(ACC_W)) u_ir_pd_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .in_last   (in_last),
    .out_code  (out_code),
    .out_valid (out_valid),
    .out_err   (out_err),
    .ph_q      (ph_q),
    .acc_q     (acc_q)
);

// File: tb/ir_pd_decoder_bench.sv
module ir_pd_decoder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        in_last = 1'b0;
    logic        in_ready;
    logic [31:0] out_code;
    logic        out_valid;
    logic        out_err;

    int n_checks = 0;
    int n_fail   = 0;
    int inj_bit  = -1;   // bit index whose mark or space is overridden
    int inj_mark = 0;
    int inj_space = 0;

    always #4 clk = ~clk;   // 125 MHz

    ir_pd_decoder u_ir_pd_decoder (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_last   (in_last),
        .in_ready  (in_ready),
        .out_code  (out_code),
        .out_valid (out_valid),
        .out_err   (out_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One run: level (1 = mark), length 1..128.
    task automatic send_byte(input bit lvl, input int len, input bit last);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_data  = {lvl, 7'(len - 1)};
        in_last  = last;
    endtask

    task automatic send_space(input int len, input bit split);
        if (split && len >= 2) begin
            send_byte(1'b0, len / 2, 1'b0);
            send_byte(1'b0, len - len / 2, 1'b0);
        end else begin
            send_byte(1'b0, len, 1'b0);
        end
    endtask

    // nbits data pairs, then the closing mark; extra trailing marks after it.
    task automatic send_data(input logic [31:0] code, input int mk, input int zs, input int os,
                             input bit split, input int nbits, input int extra);
        for (int b = 0; b < nbits; b++) begin
            send_byte(1'b1, (b == inj_bit && inj_mark != 0) ? inj_mark : mk, 1'b0);
            send_space((b == inj_bit && inj_space != 0) ? inj_space : (code[b] ? os : zs), split);
        end
        send_byte(1'b1, mk, extra == 0);
        for (int e = 0; e < extra; e++) send_byte(1'b1, 5, e == extra - 1);
    endtask

    // Sample in the cycle after the last byte, then one cycle later.
    task automatic expect_result(input string req, input bit ok, input logic [31:0] code);
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
        chk({req, " valid"}, 32'(out_valid), 32'(ok));
        chk({req, " err"}, 32'(out_err), 32'(!ok));
        chk({req, " code"}, out_code, ok ? code : 32'hFFFF_FFFF);
    endtask

    task automatic expect_hold(input string req, input logic [31:0] code);
        @(negedge clk);
        chk({req, " strobes drop"}, 32'({out_valid, out_err}), 32'd0);
        chk({req, " code held"}, out_code, code);
    endtask

    function automatic logic [31:0] mk_code(input logic [15:0] addr, input logic [7:0] cmd);
        return {~cmd, cmd, addr};
    endfunction

    initial begin : main
        logic [31:0] c;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 ready", 32'(in_ready), 32'd1);
        chk("R1 valid", 32'(out_valid), 32'd0);
        chk("R1 err", 32'(out_err), 32'd0);
        chk("R1 code", out_code, 32'd0);
        rst_n = 1'b1;

        // R5 R8 R1: sweep every command value with varied timings
        for (int i = 0; i < 256; i++) begin
            c = mk_code(16'(i * 257) ^ 16'h1234, 8'(i));
            send_byte(1'b1, 100, 1'b0);
            send_byte(1'b0, 60, 1'b0);
            send_data(c, 1 + (i % 26), 1 + ((i * 7) % 26), 27 + ((i * 3) % 27), i[0], 32, 0);
            expect_result("R5 sweep", 1'b1, c);
        end
        expect_hold("R7 hold after valid", c);

        // R4 R5: exact boundaries mark 26, zero space 26, one space 53
        c = mk_code(16'hA5C3, 8'h3C);
        send_byte(1'b1, 100, 1'b0); send_byte(1'b0, 60, 1'b0);
        send_data(c, 26, 26, 53, 1'b1, 32, 0);
        expect_result("R5 boundary 26/53", 1'b1, c);
        // R5: one space of 27 still decodes as 1
        c = mk_code(16'hFFFF, 8'h00);
        send_byte(1'b1, 100, 1'b0); send_byte(1'b0, 60, 1'b0);
        send_data(c, 10, 1, 27, 1'b0, 32, 0);
        expect_result("R5 one at 27", 1'b1, c);

        // R4: data mark of 27 aborts
        inj_bit = 5; inj_mark = 27;
        send_byte(1'b1, 100, 1'b0); send_byte(1'b0, 60, 1'b0);
        send_data(mk_code(16'h0F0F, 8'h11), 10, 10, 40, 1'b0, 32, 0);
        expect_result("R4 pulse error", 1'b0, 32'h0);
        expect_hold("R7 hold after err", 32'hFFFF_FFFF);
        // R5: data space of 54 aborts
        inj_mark = 0; inj_bit = 7; inj_space = 54;
        send_byte(1'b1, 100, 1'b0); send_byte(1'b0, 60, 1'b0);
        send_data(mk_code(16'h0F0F, 8'h11), 10, 10, 40, 1'b1, 32, 0);
        expect_result("R5 distance error", 1'b0, 32'h0);
        inj_bit = -1; inj_space = 0;

        // R8 R10: inverse mismatch, then a good frame right after
        send_byte(1'b1, 100, 1'b0); send_byte(1'b0, 60, 1'b0);
        send_data(32'h5A5A_1234, 10, 10, 40, 1'b0, 32, 0);
        expect_result("R8 bad inverse", 1'b0, 32'h0);
        c = mk_code(16'h4321, 8'h5A);
        send_byte(1'b1, 100, 1'b0); send_byte(1'b0, 60, 1'b0);
        send_data(c, 10, 10, 40, 1'b0, 32, 0);
        expect_result("R10 recover", 1'b1, c);

        // R8: truncated after 20 bits; R8: packet ends inside leader
        send_byte(1'b1, 100, 1'b0); send_byte(1'b0, 60, 1'b0);
        send_data(c, 10, 10, 40, 1'b0, 20, 0);
        expect_result("R8 truncated", 1'b0, 32'h0);
        send_byte(1'b1, 100, 1'b0); send_byte(1'b0, 60, 1'b1);
        expect_result("R8 end in leader", 1'b0, 32'h0);

        // R6: trailing bytes after 32 bits are ignored
        c = mk_code(16'hBEEF, 8'h81);
        send_byte(1'b1, 100, 1'b0); send_byte(1'b0, 60, 1'b0);
        send_data(c, 10, 10, 40, 1'b0, 32, 6);
        expect_result("R6 trailing ignored", 1'b1, c);

        // R2: space first clears preset; leader mark of exactly 80 rejected, 81 accepted
        send_byte(1'b0, 5, 1'b0); send_byte(1'b1, 80, 1'b0); send_byte(1'b0, 60, 1'b0);
        send_data(c, 10, 10, 40, 1'b0, 32, 0);
        expect_result("R2 leader 80", 1'b0, 32'h0);
        send_byte(1'b0, 5, 1'b0); send_byte(1'b1, 81, 1'b0); send_byte(1'b0, 60, 1'b0);
        send_data(c, 10, 10, 40, 1'b0, 32, 0);
        expect_result("R2 leader 81", 1'b1, c);
        // R2: preset counts, so a short first mark suffices
        send_byte(1'b1, 1, 1'b0); send_byte(1'b0, 60, 1'b0);
        send_data(c, 10, 10, 40, 1'b0, 32, 0);
        expect_result("R2 preset", 1'b1, c);

        // R3: leader space 40 retries inside the space phase, 41 passes
        send_byte(1'b1, 100, 1'b0); send_byte(1'b0, 40, 1'b0);
        send_byte(1'b1, 10, 1'b0); send_byte(1'b0, 41, 1'b0);
        send_data(c, 10, 10, 40, 1'b0, 32, 0);
        expect_result("R3 retry then 41", 1'b1, c);
        send_byte(1'b1, 100, 1'b0); send_byte(1'b0, 40, 1'b0); send_byte(1'b1, 10, 1'b1);
        expect_result("R3 space 40 only", 1'b0, 32'h0);

        // R9: mark sum 4106 and space sum 4096 saturate instead of wrapping
        c = mk_code(16'h7E57, 8'hC4);
        send_byte(1'b0, 5, 1'b0);
        for (int k = 0; k < 32; k++) send_byte(1'b1, 128, 1'b0);
        send_byte(1'b1, 10, 1'b0);
        for (int k = 0; k < 32; k++) send_byte(1'b0, 128, 1'b0);
        send_data(c, 10, 10, 40, 1'b0, 32, 0);
        expect_result("R9 saturate", 1'b1, c);

        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule